// File: doc/BRIEF.md
# Real-Time Timer Controller

This block is a free-running real-time timer with a 47-bit count that advances by one on each rising edge of a slow timer clock. Software never reads or loads the count directly. A capture buffer stands between them. A self-clearing capture command copies the live count into the buffer, and a self-clearing set command copies the buffer into the count. An alarm register is compared against the count with a greater-or-equal test. A missing-clock detector on the system clock watches for the timer clock going silent. Both conditions raise sticky flags, and those flags drive an interrupt request.

Every internal register is reached through an indirect window of two ports. When the select input is low, a write loads an index register. When the select input is high, a write or read goes to the internal register that the index points at. The timer clock is sampled on the system clock through a synchronizer chain. Every piece of state lives in the system-clock domain, so no multi-bit value crosses clock domains.

Top module: `rtc_timer_ctrl`

## Requirements
- R1: The 47-bit timer advances by exactly one per rising edge of `rtc_clk_in` only while control bit 7 (enable) and control bit 4 (run) are both 1. Otherwise it holds its value. Counting past all ones wraps to zero.
- R2: Writing control bit 1 (set) as 1 loads the timer from the capture buffer on the next system clock edge. The bit reads 1 until that edge and reads 0 after it.
- R3: Writing control bit 0 (capture) as 1 copies the timer into the capture buffer on the next system clock edge, and the bit then reads 0. When set and capture are written together, the timer and the buffer exchange values.
- R4: While control bit 3 (alarm enable) is 1 and the timer is greater than or equal to the alarm register, control bit 2 (alarm flag) becomes 1 within three system cycles. While bit 3 is 0, the flag is never set.
- R5: The alarm flag (bit 2) and the clock-fail flag (bit 5) are never cleared by hardware. A control write with the bit at 0 clears it, and a control write with the bit at 1 does not set it.
- R6: While control bit 6 (detector enable) is 1, a run of TIMEOUT system cycles (2500 by default, one 20 kHz period at 50 MHz) with no rising timer-clock edge sets bit 5 once for that episode. While bit 6 is 0, bit 5 is never set.
- R7: With `bus_sel`=0, writes load the index and reads return it zero-extended (4 bits by default). With `bus_sel`=1, the access goes to the register at the index. Capture bytes sit at indices 0 to 5, least significant first. The control register is at index 6. Alarm bytes sit at indices 8 to 13. Bit 7 of the top byte of each 47-bit register reads 0. Unmapped indices read 0 and ignore writes.
- R8: `irq` equals `irq_en` AND (alarm flag OR clock-fail flag).
- R9: After reset, the timer, capture buffer, alarm register, control register and index all read 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rtc_clk_in | input | 1 | Slow timer clock, asynchronous to `clk` |
| bus_sel | input | 1 | 0 selects the index register, 1 selects the data window |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| irq_en | input | 1 | Interrupt enable from the CPU side |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a set and a capture landing on the same edge. The bench writes both command bits in one control write, so the two transfers happen together, and then checks that the values were swapped. It is also hard to see a command bit while it is still pending. The bench reads the control byte in the same half cycle that the write ends, before the transfer edge. The clock-fail path is reached by holding the timer clock still for more than TIMEOUT cycles. The bench then clears the flag while the detector stays on, to show that the flag does not fire a second time.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   // Control byte, bit 7 down to bit 0; the order is software-visible.
   typedef struct packed {
      logic en;       // 7 oscillator/timer enable
      logic mcd_en;   // 6 missing-clock detector enable
      logic fail;     // 5 sticky clock-fail flag
      logic run;      // 4 run control
      logic aen;      // 3 alarm enable
      logic aflag;    // 2 sticky alarm flag
      logic set_cmd;  // 1 buffer -> timer, self clearing
      logic cap_cmd;  // 0 timer -> buffer, self clearing
   } ctrl_t;

   localparam int CAP_BASE  = 0;
   localparam int CTRL_IDX  = 6;
   localparam int ALM_BASE  = 8;

endpackage

// File: rtl/rtc_edge_sync.sv
module rtc_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rtc_edge_sync: STAGES must be at least 2");
   end

   // sh[STAGES-1] is the settled sample, sh[STAGES] the previous one.
   logic [STAGES:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], async_in};
   end

   assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/rtc_clock_watch.sv
module rtc_clock_watch #(
   parameter int TIMEOUT = 2500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic tick,
   output logic fail_pulse
);
   if (TIMEOUT < 2) begin : g_bad_timeout
      $error("rtc_clock_watch: TIMEOUT must be at least 2");
   end

   localparam int CW = $clog2(TIMEOUT + 1);

   logic [CW-1:0] cnt;

   // Counts silent cycles and saturates at TIMEOUT, so one loss gives one pulse.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (!enable || tick)     cnt <= '0;
      else if (cnt != CW'(TIMEOUT)) cnt <= cnt + 1'b1;
   end

   assign fail_pulse = enable && !tick && (cnt == CW'(TIMEOUT - 1));

   assert_one_shot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fail_pulse |=> !fail_pulse);
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
   parameter int W  = 47,
   parameter int NB = (W + 7) / 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          run_ok,
   input  logic          do_set,
   input  logic          do_cap,
   input  logic [NB-1:0] cap_we,
   input  logic [7:0]    wdata,
   output logic [W-1:0]  timer_q,
   output logic [W-1:0]  cap_q
);
   if (NB * 8 < W) begin : g_bad_nb
      $error("rtc_timebase: NB too small for W");
   end

   logic [W-1:0] lane_mask;
   logic [W-1:0] lane_data;

   for (genvar i = 0; i < W; i++) begin : g_lane
      assign lane_mask[i] = cap_we[i / 8];
      assign lane_data[i] = wdata[i % 8];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               timer_q <= '0;
      else if (do_set)          timer_q <= cap_q;
      else if (run_ok && tick)  timer_q <= timer_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cap_q <= '0;
      else if (|cap_we)   cap_q <= (cap_q & ~lane_mask) | (lane_data & lane_mask);
      else if (do_cap)    cap_q <= timer_q;
   end

   assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!do_set && !(run_ok && tick)) |=> $stable(timer_q));
   assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!do_set && run_ok && tick) |=> timer_q == $past(timer_q) + W'(1));
   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      do_set |=> timer_q == $past(cap_q));
   assert_snap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (do_cap && !(|cap_we)) |=> cap_q == $past(timer_q));
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
   parameter int W       = 47,
   parameter bit REG_CMP = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] timer,
   input  logic [W-1:0] alarm,
   output logic         ge
);
   if (REG_CMP) begin : g_registered
      logic ge_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ge_r <= 1'b0;
         else        ge_r <= (timer >= alarm);
      end
      assign ge = ge_r;
   end else begin : g_direct
      assign ge = (timer >= alarm);
   end
endmodule

// File: rtl/rtc_timer_ctrl.sv
module rtc_timer_ctrl
   import rtc_pkg::*;
#(
   parameter int TIMER_W     = 47,
   parameter int ADDR_W      = 4,
   parameter int SYS_CLK_HZ  = 50_000_000,
   parameter int MIN_RTC_HZ  = 20_000,
   parameter int SYNC_STAGES = 2,
   parameter bit REG_CMP     = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rtc_clk_in,
   input  logic       bus_sel,
   input  logic       bus_wr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   input  logic       irq_en,
   output logic       irq
);
   localparam int NB      = (TIMER_W + 7) / 8;
   localparam int BW      = NB * 8;
   localparam int TIMEOUT = SYS_CLK_HZ / MIN_RTC_HZ;

   if (NB > CTRL_IDX - CAP_BASE) begin : g_bad_cap_span
      $error("rtc_timer_ctrl: capture bytes overlap the control index");
   end
   if (ALM_BASE + NB > (1 << ADDR_W) || ADDR_W > 8) begin : g_bad_addr
      $error("rtc_timer_ctrl: ADDR_W cannot hold the register window");
   end
   if (TIMER_W <= 8) begin : g_bad_width
      $error("rtc_timer_ctrl: TIMER_W must exceed one byte");
   end

   logic [ADDR_W-1:0]  idx_q;
   ctrl_t              ctrl_q;
   logic [TIMER_W-1:0] alm_q;
   logic [TIMER_W-1:0] timer_q;
   logic [TIMER_W-1:0] cap_q;
   logic [NB-1:0]      cap_we;
   logic [NB-1:0]      alm_we;
   logic               wr_data, wr_idx, ctrl_we;
   logic               tick, ge, fail_pulse;

   assign wr_idx  = bus_wr && !bus_sel;
   assign wr_data = bus_wr && bus_sel;
   assign ctrl_we = wr_data && (idx_q == ADDR_W'(CTRL_IDX));

   for (genvar b = 0; b < NB; b++) begin : g_byte_we
      assign cap_we[b] = wr_data && (idx_q == ADDR_W'(CAP_BASE + b));
      assign alm_we[b] = wr_data && (idx_q == ADDR_W'(ALM_BASE + b));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx_q <= '0;
      else if (wr_idx) idx_q <= bus_wdata[ADDR_W-1:0];
   end

   rtc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(rtc_clk_in), .rise(tick));

   rtc_clock_watch #(.TIMEOUT(TIMEOUT)) u_watch (
      .clk(clk), .rst_n(rst_n), .enable(ctrl_q.mcd_en), .tick(tick),
      .fail_pulse(fail_pulse));

   rtc_timebase #(.W(TIMER_W), .NB(NB)) u_base (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .run_ok(ctrl_q.en && ctrl_q.run),
      .do_set(ctrl_q.set_cmd), .do_cap(ctrl_q.cap_cmd),
      .cap_we(cap_we), .wdata(bus_wdata),
      .timer_q(timer_q), .cap_q(cap_q));

   rtc_alarm_cmp #(.W(TIMER_W), .REG_CMP(REG_CMP)) u_cmp (
      .clk(clk), .rst_n(rst_n), .timer(timer_q), .alarm(alm_q), .ge(ge));

   // Alarm register, byte lanes.
   logic [TIMER_W-1:0] alm_mask, alm_data;
   for (genvar i = 0; i < TIMER_W; i++) begin : g_alm_lane
      assign alm_mask[i] = alm_we[i / 8];
      assign alm_data[i] = bus_wdata[i % 8];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        alm_q <= '0;
      else if (|alm_we)  alm_q <= (alm_q & ~alm_mask) | (alm_data & alm_mask);
   end

   // Control register: plain bits, self-clearing commands, sticky flags.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else begin
         if (ctrl_we) begin
            ctrl_q.en      <= bus_wdata[7];
            ctrl_q.mcd_en  <= bus_wdata[6];
            ctrl_q.run     <= bus_wdata[4];
            ctrl_q.aen     <= bus_wdata[3];
            ctrl_q.set_cmd <= bus_wdata[1];
            ctrl_q.cap_cmd <= bus_wdata[0];
         end else begin
            ctrl_q.set_cmd <= 1'b0;
            ctrl_q.cap_cmd <= 1'b0;
         end
         if (ctrl_q.aen && ge)                ctrl_q.aflag <= 1'b1;
         else if (ctrl_we && !bus_wdata[2])   ctrl_q.aflag <= 1'b0;
         if (fail_pulse)                      ctrl_q.fail  <= 1'b1;
         else if (ctrl_we && !bus_wdata[5])   ctrl_q.fail  <= 1'b0;
      end
   end

   // Read window.
   logic [BW-1:0] cap_pad, alm_pad;
   logic [7:0]    win_rd;
   assign cap_pad = BW'(cap_q);
   assign alm_pad = BW'(alm_q);

   always_comb begin
      win_rd = 8'h00;
      for (int k = 0; k < NB; k++) begin
         if (idx_q == ADDR_W'(CAP_BASE + k)) win_rd = cap_pad[8*k +: 8];
         if (idx_q == ADDR_W'(ALM_BASE + k)) win_rd = alm_pad[8*k +: 8];
      end
      if (idx_q == ADDR_W'(CTRL_IDX)) win_rd = ctrl_q;
   end

   assign bus_rdata = bus_sel ? win_rd : 8'(idx_q);
   assign irq       = irq_en && (ctrl_q.aflag || ctrl_q.fail);

   assert_cmd_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.set_cmd && !ctrl_we) |=> !ctrl_q.set_cmd);
   assert_cap_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.cap_cmd && !ctrl_we) |=> !ctrl_q.cap_cmd);
   assert_alarm_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.aen && ge) |=> ctrl_q.aflag);
   assert_alarm_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.aflag && !ctrl_we) |=> ctrl_q.aflag);
   assert_fail_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.fail && !ctrl_we) |=> ctrl_q.fail);
   assert_fail_needs_det_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl_q.fail) |-> $past(ctrl_q.mcd_en));
   assert_no_irq_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);
endmodule

// File: tb/tb_rtc_timer_ctrl.sv
module tb_rtc_timer_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rtc_clk_in = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       irq_en = 1'b0;
   logic       irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   rtc_timer_ctrl dut (
      .clk(clk), .rst_n(rst_n), .rtc_clk_in(rtc_clk_in),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_en(irq_en), .irq(irq));

   // kind: 0 load index, 1 write window, 2 read window, 3 read index
   localparam int NV = 24;
   localparam logic [17:0] VEC [NV] = '{
      {2'd0, 8'h08, 8'h00}, {2'd1, 8'h11, 8'h00},
      {2'd0, 8'h0D, 8'h00}, {2'd1, 8'hFF, 8'h00},
      {2'd0, 8'h00, 8'h00}, {2'd1, 8'h5A, 8'h00},
      {2'd0, 8'h05, 8'h00}, {2'd1, 8'hFF, 8'h00},
      {2'd0, 8'h07, 8'h00}, {2'd1, 8'hAA, 8'h00},
      {2'd0, 8'h08, 8'h00}, {2'd2, 8'h00, 8'h11},
      {2'd0, 8'h0D, 8'h00}, {2'd2, 8'h00, 8'h7F},
      {2'd0, 8'h00, 8'h00}, {2'd2, 8'h00, 8'h5A},
      {2'd0, 8'h05, 8'h00}, {2'd2, 8'h00, 8'h7F},
      {2'd0, 8'h07, 8'h00}, {2'd2, 8'h00, 8'h00},
      {2'd0, 8'h0F, 8'h00}, {2'd2, 8'h00, 8'h00},
      {2'd0, 8'hF3, 8'h00}, {2'd3, 8'h00, 8'h03}
   };

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic bus_op(input logic sel, input logic [7:0] d);
      @(negedge clk);
      bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_now(input logic sel, output logic [7:0] v);
      bus_sel = sel;
      #1 v = bus_rdata;
   endtask

   task automatic wr_reg(input int idx, input logic [7:0] d);
      bus_op(1'b0, 8'(idx));
      bus_op(1'b1, d);
   endtask

   task automatic rd_reg(input int idx, output logic [7:0] v);
      bus_op(1'b0, 8'(idx));
      rd_now(1'b1, v);
   endtask

   task automatic wr_wide(input int base, input logic [46:0] val);
      logic [47:0] p;
      p = {1'b0, val};
      for (int k = 0; k < 6; k++) wr_reg(base + k, p[8*k +: 8]);
   endtask

   task automatic chk_wide(input int base, input logic [46:0] exp, input string req);
      logic [47:0] acc;
      logic [7:0]  v;
      for (int k = 0; k < 6; k++) begin
         rd_reg(base + k, v);
         acc[8*k +: 8] = v;
      end
      check(req, acc, {1'b0, exp});
   endtask

   task automatic chk_ctrl(input logic [7:0] exp, input string req);
      logic [7:0] v;
      rd_reg(6, v);
      check(req, v, exp);
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         rtc_clk_in = 1'b1;
         repeat (4) @(negedge clk);
         rtc_clk_in = 1'b0;
         repeat (4) @(negedge clk);
      end
   endtask

   task automatic snap(input logic [7:0] keep);
      wr_reg(6, keep | 8'h01);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [46:0] base_v;
      base_v = 47'h1234_5678_9ABC;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 reset state
      rd_now(1'b0, v);            check("R9 index", v, 8'h00);
      rd_now(1'b1, v);            check("R9 capture byte0", v, 8'h00);
      check("R9 irq", irq, 1'b0);
      chk_ctrl(8'h00, "R9 control");
      chk_wide(8, 47'h0, "R9 alarm");

      // R7 register window walk
      for (int i = 0; i < NV; i++) begin
         case (VEC[i][17:16])
            2'd0: bus_op(1'b0, VEC[i][15:8]);
            2'd1: bus_op(1'b1, VEC[i][15:8]);
            2'd2: begin rd_now(1'b1, v); check("R7 window read", v, VEC[i][7:0]); end
            default: begin rd_now(1'b0, v); check("R7 index read", v, VEC[i][7:0]); end
         endcase
      end

      // R2 set command, pending then cleared
      wr_wide(0, base_v);
      wr_reg(6, 8'h02);
      rd_now(1'b1, v);            check("R2 set pending", v, 8'h02);
      @(negedge clk);
      rd_now(1'b1, v);            check("R2 set self-clears", v, 8'h00);
      wr_wide(0, 47'h0);
      snap(8'h00);
      chk_wide(0, base_v, "R3 capture after R2 set");
      chk_ctrl(8'h00, "R3 capture self-clears");

      // R1 counting gated by enable and run
      wr_reg(6, 8'h90);
      pulses(5);
      snap(8'h90);
      chk_wide(0, base_v + 47'd5, "R1 counts five edges");
      wr_reg(6, 8'h80);
      pulses(3);
      snap(8'h80);
      chk_wide(0, base_v + 47'd5, "R1 hold with run off");
      wr_reg(6, 8'h10);
      pulses(3);
      snap(8'h10);
      chk_wide(0, base_v + 47'd5, "R1 hold with enable off");

      // R1 wrap at all ones
      wr_wide(0, {47{1'b1}});
      wr_reg(6, 8'h02);
      repeat (2) @(negedge clk);
      wr_reg(6, 8'h90);
      pulses(1);
      snap(8'h90);
      chk_wide(0, 47'h0, "R1 wrap to zero");

      // R3 set and capture together swap values
      wr_wide(0, 47'h55);
      wr_reg(6, 8'h03);
      repeat (2) @(negedge clk);
      chk_wide(0, 47'h0, "R3 swap buffer gets old timer");
      snap(8'h00);
      chk_wide(0, 47'h55, "R3 swap timer got old buffer");

      // R4 / R5 / R8 alarm
      wr_wide(0, 47'd100);
      wr_reg(6, 8'h02);
      repeat (2) @(negedge clk);
      wr_wide(8, 47'd103);
      wr_reg(6, 8'h98);
      irq_en = 1'b1;
      pulses(2);
      chk_ctrl(8'h98, "R4 below alarm no flag");
      check("R8 irq idle", irq, 1'b0);
      pulses(1);
      chk_ctrl(8'h9C, "R4 equal sets flag");
      check("R8 irq on alarm", irq, 1'b1);
      irq_en = 1'b0;
      #1 check("R8 irq masked", irq, 1'b0);
      irq_en = 1'b1;
      wr_wide(8, {47{1'b1}});
      chk_ctrl(8'h9C, "R5 alarm flag sticky");
      wr_reg(6, 8'h98);
      chk_ctrl(8'h98, "R5 alarm flag cleared by 0");
      check("R8 irq after clear", irq, 1'b0);
      wr_reg(6, 8'h9C);
      chk_ctrl(8'h98, "R5 writing 1 does not set");
      wr_reg(6, 8'h90);
      wr_wide(8, 47'd5);
      repeat (3) @(negedge clk);
      chk_ctrl(8'h90, "R4 disabled alarm never sets");
      wr_reg(6, 8'h98);
      repeat (3) @(negedge clk);
      chk_ctrl(8'h9C, "R4 greater sets flag");
      wr_wide(8, {47{1'b1}});
      wr_reg(6, 8'h90);
      chk_ctrl(8'h90, "R5 clear before detector test");

      // R6 missing-clock detector
      wr_reg(6, 8'hC0);
      repeat (2000) @(negedge clk);
      chk_ctrl(8'hC0, "R6 no fail before timeout");
      repeat (600) @(negedge clk);
      chk_ctrl(8'hE0, "R6 fail after timeout");
      check("R8 irq on fail", irq, 1'b1);
      wr_reg(6, 8'hC0);
      repeat (5) @(negedge clk);
      chk_ctrl(8'hC0, "R6 one set per episode");
      pulses(400);
      chk_ctrl(8'hC0, "R6 clock present no fail");
      wr_reg(6, 8'h80);
      repeat (3000) @(negedge clk);
      chk_ctrl(8'h80, "R6 detector off never sets");
      check("R8 irq quiet", irq, 1'b0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule